// File: doc/BRIEF.md
# Link Self-Test Receive Checker

This block is the receive end of a serial link self-test. A test is started by raising either of two enable inputs, one driven from a board pin and one from a configuration bit. While either is high, the block asks the far-end transmitter to send its test stream. Once the link reports lock, the block checks every received frame against the expected descrambled pattern, which is all zeros. Only payload bits 1 through 35 of each frame take part in the check.

A single PASS output reports the result. While the test runs, PASS sits high and drops low for the second half of one pixel-clock period for each frame that held at least one wrong bit. When both enables fall, checking stops and PASS keeps the verdict: high for a clean run, low if any frame was wrong. The verdict stays until a new test starts, a reset, or a power-down. A saturating count of errored frames can be read during and after the test. A clock-source select, taken from a pin or a register bit, is passed on registered.

Top module: `bist_link_checker`

## Requirements
- R1: `bist_req_o` is high in the cycle after an edge that sampled either enable input high (with `pwrdn_i` low), and low in the cycle after an edge that sampled both enables low.
- R2: `osc_sel_o` (1 = internal oscillator, 0 = external link clock) becomes the OR of `clksel_pin_i` and `clksel_reg_i`, as sampled at the previous edge.
- R3: After reset, and while a test is enabled but lock has not yet been seen, PASS is low. PASS is high in the cycle after the first edge that samples enable and `lock_i` both high.
- R4: Only frame bits 1 to 35 are compared with zero. A frame whose only set bits are bit 0 or bits 36 to 39 gives no pulse, no count and no fail verdict.
- R5: A frame sampled at an edge with enable and lock high and a nonzero checked bit makes PASS high in the first half and low in the second half of the following cycle. Any number of wrong bits in one frame gives exactly one such pulse.
- R6: Frames sampled while enable is low or `lock_i` is low are not checked. They cause no pulse and no count.
- R7: After an edge that samples both enables low following a locked run, PASS stays constantly high if no frame was errored, and constantly low otherwise.
- R8: A held verdict is unchanged by idle cycles. It is cleared by a new test start, which restarts the fail record. It is also cleared by `rst` or `pwrdn_i`, which drive PASS, `bist_req_o` and the count to 0.
- R9: `err_cnt_o` counts checked errored frames and saturates at 65535. It is cleared at the edge that starts a new test and holds its value after the test ends.
- R10: While `pwrdn_i` is high, enables are ignored: no test starts and `bist_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrdn_i | input | 1 | Synchronous power-down; clears all state |
| bist_pin_i | input | 1 | Test enable from pin |
| bist_reg_i | input | 1 | Test enable from configuration bit |
| clksel_pin_i | input | 1 | Oscillator select from pin |
| clksel_reg_i | input | 1 | Oscillator select from configuration bit |
| lock_i | input | 1 | Link lock indication |
| frame_i | input | 40 | Received descrambled frame, one per clock |
| bist_req_o | output | 1 | Test request toward the transmitter |
| osc_sel_o | output | 1 | Selected test clock source |
| pass_o | output | 1 | Pulsed / held test result |
| err_cnt_o | output | 16 | Saturating errored-frame count |

## Verification
Each result is due in the cycle that follows the edge that sampled its stimulus. The request, clock select, PASS level and count all come from one register stage. The error pulse occupies only the low phase of that same following cycle. The bench changes inputs after the low-phase sample and waits for the next rising edge. It then reads PASS once a moment after the rise, expecting the high half, and once after the fall, expecting the low half. So every pulse is checked for both its presence and its half-period shape. The saturation case drives enough errored frames to pass the counter limit, then starts a new test and confirms the count returns to zero.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  // Test phase kept by the sequencer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no verdict since reset
    PH_ARMED = 2'd1,  // enabled, waiting for lock
    PH_RUN   = 2'd2,  // checking frames
    PH_HELD  = 2'd3   // test over, verdict held
  } bist_phase_e;

endpackage

// File: rtl/bist_frame_cmp.sv
module bist_frame_cmp #(
  parameter int FRAME_W = 40,
  parameter int CHK_LO  = 1,
  parameter int CHK_HI  = 35
) (
  input  logic [FRAME_W-1:0] frame_i,
  output logic               mismatch_o
);

  function automatic logic [FRAME_W-1:0] build_mask();
    logic [FRAME_W-1:0] m;
    m = '0;
    for (int b = 0; b < FRAME_W; b++) begin
      if (b >= CHK_LO && b <= CHK_HI) m[b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [FRAME_W-1:0] WIN_MASK = build_mask();

  // expected descrambled payload is all zeros
  assign mismatch_o = |(frame_i & WIN_MASK);

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_chk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_i,
  input  logic bist_pin_i,
  input  logic bist_reg_i,
  input  logic lock_i,
  input  logic mismatch_i,
  output logic req_o,
  output logic start_o,
  output logic hit_o,
  output logic pass_lvl_o,
  output logic pulse_o
);

  bist_phase_e st_q, st_n;
  logic en_c, start_c, chk_c, hit_c;
  logic fail_q, fail_n;
  logic lvl_q, pulse_q, req_q;

  assign en_c    = (bist_pin_i | bist_reg_i) & ~pwrdn_i;
  assign start_c = en_c & ((st_q == PH_IDLE) | (st_q == PH_HELD));
  assign chk_c   = en_c & lock_i;
  assign hit_c   = chk_c & mismatch_i;
  assign fail_n  = (start_c ? 1'b0 : fail_q) | hit_c;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      PH_IDLE, PH_HELD: if (en_c) st_n = lock_i ? PH_RUN : PH_ARMED;
      PH_ARMED: begin
        if (!en_c)       st_n = PH_IDLE;
        else if (lock_i) st_n = PH_RUN;
      end
      PH_RUN: if (!en_c) st_n = PH_HELD;
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || pwrdn_i) begin
      st_q    <= PH_IDLE;
      fail_q  <= 1'b0;
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      fail_q  <= fail_n;
      lvl_q   <= (st_n == PH_RUN) | ((st_n == PH_HELD) & ~fail_n);
      pulse_q <= hit_c;
      req_q   <= en_c;
    end
  end

  assign req_o      = req_q;
  assign start_o    = start_c;
  assign hit_o      = hit_c;
  assign pass_lvl_o = lvl_q;
  assign pulse_o    = pulse_q;

  // R5
  pulse_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (lvl_q && st_q == PH_RUN));
  // R6
  no_check_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_c || !lock_i) |=> !pulse_q);
  // R8
  start_clears_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (start_c && !hit_c) |=> !fail_q);
  // R7
  held_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_HELD) |-> (lvl_q == !fail_q));
  // R10
  pwrdn_req_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> !req_q);

endmodule

// File: rtl/bist_err_cnt.sv
module bist_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (clr_i)                   cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  // R9
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q <= 1);

endmodule

// File: rtl/bist_pass_drv.sv
module bist_pass_drv (
  input  logic clk,
  input  logic lvl_i,
  input  logic pulse_i,
  output logic pass_o
);

  // registered flag changes just after the rising edge, while the low-phase
  // term is still inactive, so the gated result has no glitch
  assign pass_o = lvl_i & ~(pulse_i & ~clk);

endmodule

// File: rtl/bist_link_checker.sv
module bist_link_checker #(
  parameter int FRAME_W = 40,
  parameter int CHK_LO  = 1,
  parameter int CHK_HI  = 35,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrdn_i,
  input  logic               bist_pin_i,
  input  logic               bist_reg_i,
  input  logic               clksel_pin_i,
  input  logic               clksel_reg_i,
  input  logic               lock_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bist_req_o,
  output logic               osc_sel_o,
  output logic               pass_o,
  output logic [CNT_W-1:0]   err_cnt_o
);

  logic mismatch, start, hit, lvl, pulse, clr_all, osc_q;

  assign clr_all = rst | pwrdn_i;

  bist_frame_cmp #(.FRAME_W(FRAME_W), .CHK_LO(CHK_LO), .CHK_HI(CHK_HI)) u_cmp (
    .frame_i    (frame_i),
    .mismatch_o (mismatch)
  );

  bist_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pwrdn_i    (pwrdn_i),
    .bist_pin_i (bist_pin_i),
    .bist_reg_i (bist_reg_i),
    .lock_i     (lock_i),
    .mismatch_i (mismatch),
    .req_o      (bist_req_o),
    .start_o    (start),
    .hit_o      (hit),
    .pass_lvl_o (lvl),
    .pulse_o    (pulse)
  );

  bist_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (clr_all),
    .clr_i (start),
    .inc_i (hit),
    .cnt_o (err_cnt_o)
  );

  bist_pass_drv u_drv (
    .clk     (clk),
    .lvl_i   (lvl),
    .pulse_i (pulse),
    .pass_o  (pass_o)
  );

  always_ff @(posedge clk) begin
    if (rst) osc_q <= 1'b0;
    else     osc_q <= clksel_pin_i | clksel_reg_i;
  end
  assign osc_sel_o = osc_q;

  // R1
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwrdn_i && (bist_pin_i || bist_reg_i)) |=> bist_req_o);
  // R2
  osc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (clksel_pin_i || clksel_reg_i) |=> osc_sel_o);

endmodule

// File: tb/sim_bist_link_checker.sv
module sim_bist_link_checker;

  localparam int PERIOD = 10;
  localparam int FW = 40;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst, pwrdn, pin_en, reg_en, cs_pin, cs_reg, lock;
  logic [FW-1:0] frame;
  logic req, osc, pass;
  logic [CW-1:0] cnt;
  logic hi_s, lo_s;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bist_link_checker u0 (
    .clk(clk), .rst(rst), .pwrdn_i(pwrdn), .bist_pin_i(pin_en),
    .bist_reg_i(reg_en), .clksel_pin_i(cs_pin), .clksel_reg_i(cs_reg),
    .lock_i(lock), .frame_i(frame), .bist_req_o(req), .osc_sel_o(osc),
    .pass_o(pass), .err_cnt_o(cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: sample high half just after the rise, low half after the fall
  task automatic cyc();
    @(posedge clk);
    #1 hi_s = pass;
    #(PERIOD/2) lo_s = pass;
  endtask

  task automatic frm(input logic [FW-1:0] f, input int eh, input int el, input string tag);
    frame = f;
    cyc();
    chk({tag, " pass-high-half"}, int'(hi_s), eh);
    chk({tag, " pass-low-half"}, int'(lo_s), el);
  endtask

  task automatic t_reset();
    rst = 1; pwrdn = 0; pin_en = 0; reg_en = 0; cs_pin = 0; cs_reg = 0;
    lock = 0; frame = '0;
    cyc(); cyc();
    rst = 0;
    cyc();
    chk("R3 reset pass", int'(hi_s | lo_s), 0);
    chk("R1 reset req", int'(req), 0);
    chk("R8 reset cnt", int'(cnt), 0);
  endtask

  task automatic t_clksel();
    cs_pin = 1; cyc(); chk("R2 pin osc", int'(osc), 1);
    cs_pin = 0; cs_reg = 1; cyc(); chk("R2 reg osc", int'(osc), 1);
    cs_reg = 0; cyc(); chk("R2 none osc", int'(osc), 0);
  endtask

  task automatic t_armed();
    pin_en = 1; lock = 0;
    frm(40'h2, 0, 0, "R3 armed");
    chk("R1 req via pin", int'(req), 1);
    frm(40'hF_FFFF_FFFE, 0, 0, "R6 unlocked err");
    chk("R6 unlocked cnt", int'(cnt), 0);
  endtask

  task automatic t_clean();
    lock = 1;
    for (int i = 0; i < 8; i++) frm('0, 1, 1, "R3 clean run");
    pin_en = 0;
    frm('0, 1, 1, "R7 clean held");
    chk("R1 req drop", int'(req), 0);
    for (int i = 0; i < 4; i++) frm(40'h2, 1, 1, "R8 idle held");
  endtask

  task automatic t_errors();
    reg_en = 1;
    frm('0, 1, 1, "R1 reg start");
    chk("R1 req via reg", int'(req), 1);
    chk("R9 cleared at start", int'(cnt), 0);
    frm(40'h2, 1, 0, "R5 bit1");
    frm('0, 1, 1, "R5 clean between");
    frm(40'hF_FFFF_FFFE, 1, 0, "R5 all bits one pulse");
    frm(40'h8_0000_0000, 1, 0, "R5 bit35");
    frm('0, 1, 1, "R5 clean after");
    chk("R9 count 3", int'(cnt), 3);
    reg_en = 0;
    frm('0, 0, 0, "R7 fail held");
    for (int i = 0; i < 3; i++) frm('0, 0, 0, "R8 fail idle");
    chk("R9 count held", int'(cnt), 3);
  endtask

  task automatic t_ignored();
    pin_en = 1;
    frm('0, 1, 1, "R8 new test clears");
    frm(40'h1, 1, 1, "R4 bit0");
    frm(40'hF0_0000_0000, 1, 1, "R4 upper bits");
    lock = 0;
    frm(40'h4, 1, 1, "R6 lock lost");
    lock = 1;
    chk("R4 cnt zero", int'(cnt), 0);
    pin_en = 0;
    frm('0, 1, 1, "R4 verdict pass");
  endtask

  task automatic t_pwrdn();
    pwrdn = 1; pin_en = 1;
    frm('0, 0, 0, "R8 pwrdn clears");
    chk("R10 pwrdn req", int'(req), 0);
    frm(40'h2, 0, 0, "R10 pwrdn ignores en");
    chk("R10 pwrdn cnt", int'(cnt), 0);
    pwrdn = 0; pin_en = 0;
    cyc();
    pin_en = 1;
    frm(40'h2, 1, 0, "R5 after pwrdn");
    pin_en = 0;
    frm('0, 0, 0, "R7 fail verdict");
    rst = 1; cyc(); rst = 0;
    frm('0, 0, 0, "R8 rst clears verdict");
    chk("R8 rst cnt", int'(cnt), 0);
  endtask

  task automatic t_sat();
    pin_en = 1; frame = 40'h2;
    for (int i = 0; i < 65540; i++) cyc();
    chk("R9 saturate", int'(cnt), 65535);
    chk("R5 pulse during sat", int'(lo_s), 0);
    pin_en = 0; frame = '0; cyc();
    chk("R9 held after", int'(cnt), 65535);
    pin_en = 1; cyc();
    chk("R9 clear new test", int'(cnt), 0);
    pin_en = 0; cyc();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_clksel();
    t_armed();
    t_clean();
    t_errors();
    t_ignored();
    t_pwrdn();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule